// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Access Port

This block is a single byte-wide control register through which software drives a one-bit serial EEPROM by hand, one pin transition per register write. The EEPROM sits on a memory port that another agent also uses. Software first sets a request bit. The block then waits until the other agent reports the port idle, claims the port, and raises a ready bit to signal that it owns the port.

While the block owns the port, three register bits drive the EEPROM select, clock and data-in pins. A fourth bit returns the EEPROM's serial output after synchronisation. Every register write made while the port is owned drops the ready bit. The bit rises again after a fixed 800 ns, so software can poll it as a pacing timer between clock edges. The serial command protocol itself is run by software.

Top module: `ee_port_ctl`

## Requirements
- R1: After reset, `rd_data` is 0x00 and `port_req`, `port_grant`, `ee_cs`, `ee_sk` and `ee_do` are all low.
- R2: The register reads as {2'b00, request[5], ready[4], select[3], clock[2], dout[1], din[0]}. Written bits 5, 3, 2 and 1 read back unchanged. Bits 7 and 6 read 0, and a write to bit 4 has no effect.
- R3: A set request is granted only on a clock edge where `port_busy` is low. While `port_busy` stays high, `port_grant` and ready stay low.
- R4: Ready goes high on the same edge that the grant is taken, with no timer delay.
- R5: While granted, `ee_cs`, `ee_sk` and `ee_do` equal register bits 3, 2 and 1.
- R6: While not granted, `ee_cs` and `ee_sk` are held low whatever register bits 3 and 2 hold.
- R7: A write that keeps the request set while granted holds ready low for exactly ceil(CLK_MHZ*DELAY_NS/1000) cycles after the write edge. Ready returns high on the next edge.
- R8: A write during the countdown restarts the full delay from that write.
- R9: A write that clears bit 5 releases the port on that edge, so `port_grant` and ready are low right after it.
- R10: Register bit 0 shows `ee_di` two clock edges after `ee_di` changes.
- R11: Once granted, the port is kept while `port_busy` rises, as long as the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| port_busy | input | 1 | Other memory-port agent is being served |
| port_req | output | 1 | Request for the memory port (register bit 5) |
| port_grant | output | 1 | Block owns the memory port |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data driven to the EEPROM |
| ee_di | input | 1 | Data returned by the EEPROM |

## Verification
The bench builds two copies of the block from the same stimulus. One uses CLK_MHZ=250, so the pacing window is a whole 200 cycles. The other uses CLK_MHZ=33, so the window is 26.4 cycles, which must round up to 27. The second copy tests the rounding at the exact cycle where ready rises, which the first copy cannot reach. The default delay of 800 ns is kept in both. The long 200-cycle window leaves room to restart the countdown partway and measure the full window again from the second write.

// File: rtl/ee_port_pkg.sv
package ee_port_pkg;

    localparam int BIT_REQ   = 5;
    localparam int BIT_READY = 4;
    localparam int BIT_CS    = 3;
    localparam int BIT_SK    = 2;
    localparam int BIT_DOUT  = 1;
    localparam int BIT_DIN   = 0;

    typedef struct packed {
        logic req;
        logic cs;
        logic sk;
        logic dout;
    } ee_ctl_t;

    function automatic int pace_cycles(input int clk_mhz, input int delay_ns);
        return (clk_mhz * delay_ns + 999) / 1000;
    endfunction

    function automatic ee_ctl_t decode_write(input logic [7:0] v);
        ee_ctl_t c;
        c.req  = v[BIT_REQ];
        c.cs   = v[BIT_CS];
        c.sk   = v[BIT_SK];
        c.dout = v[BIT_DOUT];
        return c;
    endfunction

endpackage

// File: rtl/ee_din_sync.sv
module ee_din_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ee_port_arb.sv
module ee_port_arb (
    input  logic clk,
    input  logic rst,
    input  logic req_next,
    input  logic port_busy,
    output logic granted
);
    always_ff @(posedge clk) begin
        if (rst) granted <= 1'b0;
        else     granted <= req_next && (granted || !port_busy);
    end

    AST_GRANT_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(granted) |-> !$past(port_busy)); // R3

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        granted && req_next |=> granted); // R11
endmodule

// File: rtl/ee_pace_timer.sv
module ee_pace_timer #(
    parameter int CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)      cnt <= '0;
        else if (arm)          cnt <= CW'(CYC);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_PACE_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(CYC)); // R7

    AST_ARM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        arm && !clear |=> !expired); // R8
endmodule

// File: rtl/ee_port_ctl.sv
module ee_port_ctl
    import ee_port_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int DELAY_NS = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       port_busy,
    output logic       port_req,
    output logic       port_grant,
    output logic       ee_cs,
    output logic       ee_sk,
    output logic       ee_do,
    input  logic       ee_di
);
    localparam int PACE_CYC = pace_cycles(CLK_MHZ, DELAY_NS);

    ee_ctl_t ctl_q, ctl_next;
    logic    granted, pace_done, ready, din_s;
    logic    unused_bits;

    assign unused_bits = ^{wr_data[7:6], wr_data[BIT_READY], wr_data[BIT_DIN]};

    always_comb begin
        ctl_next = ctl_q;
        if (wr_en) ctl_next = decode_write(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_next;
    end

    ee_port_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .req_next  (ctl_next.req),
        .port_busy (port_busy),
        .granted   (granted)
    );

    ee_pace_timer #(.CYC(PACE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (wr_en && granted),
        .clear   (!ctl_next.req),
        .expired (pace_done)
    );

    ee_din_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ee_di),
        .q   (din_s)
    );

    assign ready      = granted && pace_done;
    assign port_req   = ctl_q.req;
    assign port_grant = granted;
    assign ee_cs      = granted && ctl_q.cs;
    assign ee_sk      = granted && ctl_q.sk;
    assign ee_do      = ctl_q.dout;

    always_comb begin
        rd_data            = '0;
        rd_data[BIT_REQ]   = ctl_q.req;
        rd_data[BIT_READY] = ready;
        rd_data[BIT_CS]    = ctl_q.cs;
        rd_data[BIT_SK]    = ctl_q.sk;
        rd_data[BIT_DOUT]  = ctl_q.dout;
        rd_data[BIT_DIN]   = din_s;
    end

    AST_FIRST_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(port_grant) |-> rd_data[BIT_READY]); // R4

    AST_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !port_grant |-> !ee_cs && !ee_sk); // R6

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_data[BIT_REQ] |=> !port_grant && !rd_data[BIT_READY]); // R9

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        port_grant |-> port_req); // R3
endmodule

// File: tb/ee_port_ctl_tb_top.sv
module ee_port_ctl_tb_top;

    localparam int D_FAST = 200;
    localparam int D_SLOW = 27;

    typedef struct {
        string      tag;
        bit         sel_slow;
        logic [7:0] mask_rd;
        logic [7:0] exp_rd;
        logic [4:0] mask_pin;
        logic [4:0] exp_pin;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       port_busy = 1'b0;
    logic       ee_di = 1'b0;

    logic [7:0] rd_f, rd_s;
    logic       req_f, gnt_f, cs_f, sk_f, do_f;
    logic       req_s, gnt_s, cs_s, sk_s, do_s;

    int  n_run = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  done = 0;
    item_t q[$];

    always #2 clk = ~clk;

    ee_port_ctl #(.CLK_MHZ(250)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_f),
        .port_busy(port_busy), .port_req(req_f), .port_grant(gnt_f),
        .ee_cs(cs_f), .ee_sk(sk_f), .ee_do(do_f), .ee_di(ee_di));

    ee_port_ctl #(.CLK_MHZ(33)) slow_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_s),
        .port_busy(port_busy), .port_req(req_s), .port_grant(gnt_s),
        .ee_cs(cs_s), .ee_sk(sk_s), .ee_do(do_s), .ee_di(ee_di));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic expect_all(input string tag, input logic [7:0] rd, input logic [4:0] pins);
        item_t it;
        it.tag = tag; it.sel_slow = 0;
        it.mask_rd = 8'hFF; it.exp_rd = rd;
        it.mask_pin = 5'h1F; it.exp_pin = pins;
        q.push_back(it);
    endtask

    task automatic expect_ready(input string tag, input bit slow, input logic r);
        item_t it;
        it.tag = tag; it.sel_slow = slow;
        it.mask_rd = 8'h10; it.exp_rd = {3'b000, r, 4'b0000};
        it.mask_pin = 5'h00; it.exp_pin = 5'h00;
        q.push_back(it);
    endtask

    // monitor: pops expectations and compares against the chosen instance
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] a_rd;
            logic [4:0] a_pin;
            it = q.pop_front();
            a_rd  = it.sel_slow ? rd_s : rd_f;
            a_pin = it.sel_slow ? {req_s, gnt_s, cs_s, sk_s, do_s}
                                : {req_f, gnt_f, cs_f, sk_f, do_f};
            n_run++;
            if (((a_rd & it.mask_rd) !== (it.exp_rd & it.mask_rd)) ||
                ((a_pin & it.mask_pin) !== (it.exp_pin & it.mask_pin))) begin
                n_fail++;
                $display("FAIL %s: rd=%h pins=%b expected rd=%h pins=%b",
                         it.tag, a_rd & it.mask_rd, a_pin & it.mask_pin,
                         it.exp_rd & it.mask_rd, it.exp_pin & it.mask_pin);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle=%0d expected below 20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        // pins vector order: {port_req, port_grant, ee_cs, ee_sk, ee_do}
        repeat (3) tick();
        expect_all("R1 reset state", 8'h00, 5'b00000);
        rst = 1'b0;
        tick();
        expect_all("R1 after reset release", 8'h00, 5'b00000);

        port_busy = 1'b1;
        write(8'hFE);
        expect_all("R2 R3 R6 request pending while busy", 8'h2E, 5'b10001);
        repeat (3) tick();
        expect_all("R3 still no grant while busy", 8'h2E, 5'b10001);

        port_busy = 1'b0;
        tick();
        expect_all("R4 R5 grant with immediate ready", 8'h3E, 5'b11111);

        port_busy = 1'b1;
        tick();
        expect_all("R11 grant kept while busy rises", 8'h3E, 5'b11111);

        write(8'h28);
        expect_all("R7 R5 write drops ready", 8'h28, 5'b11100);
        repeat (D_SLOW - 1) tick();
        expect_ready("R7 slow copy ready still low", 1, 1'b0);
        tick();
        expect_ready("R7 slow copy rounded-up window ends", 1, 1'b1);
        expect_ready("R7 fast copy still counting", 0, 1'b0);
        repeat (D_FAST - D_SLOW - 1) tick();
        expect_ready("R7 fast ready low on last window cycle", 0, 1'b0);
        tick();
        expect_all("R7 fast ready back high", 8'h38, 5'b11100);

        write(8'h2A);
        repeat (100) tick();
        write(8'h2C);
        expect_all("R8 R5 restart write", 8'h2C, 5'b11110);
        repeat (D_FAST - 1) tick();
        expect_ready("R8 restarted window still low", 0, 1'b0);
        tick();
        expect_ready("R8 restarted window ends", 0, 1'b1);

        ee_di = 1'b1;
        tick();
        expect_all("R10 one edge after din change", 8'h3C, 5'b11110);
        tick();
        expect_all("R10 two edges after din change", 8'h3D, 5'b11110);

        write(8'h0E);
        expect_all("R9 R6 release drops grant and ready", 8'h0F, 5'b00001);

        port_busy = 1'b1;
        write(8'h2C);
        expect_all("R3 R6 new request waits while busy", 8'h2D, 5'b10000);
        port_busy = 1'b0;
        tick();
        expect_all("R4 second grant ready at once", 8'h3D, 5'b11110);

        ee_di = 1'b0;
        repeat (2) tick();
        expect_all("R10 din falls through sync", 8'h3C, 5'b11110);

        tick();
        tick();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule